// File: doc/BRIEF.md
# Bus Cycle Address and ID Decoder

This block sits at the front of a flash-memory bus slave. When a cycle-start strobe marks a new bus cycle, it captures the 24-bit address and the 4-bit hardware ID strap. On the next clock it decides whether this device owns the cycle. If the cycle is accepted, the decision also says whether it targets the flash array or the register space. A cycle that is refused drives a standby indication, so the cycle state machine drops the rest of that cycle.

Several devices can share one bus. Each is given a different strap value: the boot device uses 0000 and the others count upward from 0001. The address carries the wanted device's ID in four non-adjacent bits, stored as the bitwise complement of the strap. Two range checks apply. For flash, all offset bits above the configured array size must be zero. For registers, all offset bits above the configured register window must be zero.

Top module: `bus_addr_id_decode`

## Requirements
- R1: A synchronous active-high reset clears accept, flash-select, register-select and standby to 0, and they stay 0 until a decision is made.
- R2: On the clock edge that samples the cycle-start strobe high, the address and strap are captured and all four outputs clear to 0. The decision for that cycle appears on the outputs at the following edge.
- R3: The ID carried in the address is the complement of {A23, A21, A20, A19}. A23 maps to strap bit 3, A21 to bit 2, A20 to bit 1 and A19 to bit 0. The cycle can be accepted only if this value equals the strap.
- R4: On an ID mismatch, the decision drives standby 1 with accept and both selects 0.
- R5: For an accepted cycle, A22 = 1 raises flash-select and A22 = 0 raises register-select. The two selects are never high together, and accept is high exactly when one of them is.
- R6: For a flash cycle, any set bit in A18 down to A[ARRAY_AW] refuses the cycle with standby. The default ARRAY_AW of 19 gives a 512 KB array with no unused bits.
- R7: For a register cycle, any set bit in A18 down to A[REG_AW] refuses the cycle with standby. REG_AW defaults to 16.
- R8: Once a decision is on the outputs, all four outputs hold their values until the next cycle-start strobe or reset.
- R9: A boot device strapped 0000 accepts only addresses whose four ID bits are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-cycle strobe marking a new bus cycle with a valid address |
| cyc_addr | input | 24 | Captured address field of the cycle |
| id_strap | input | 4 | Hardware ID strap of this device |
| accept_o | output | 1 | Cycle is owned by this device |
| flash_sel_o | output | 1 | Accepted cycle targets the flash array |
| reg_sel_o | output | 1 | Accepted cycle targets the register space |
| standby_o | output | 1 | Cycle refused; the rest of it is ignored |

## Verification
The bound checker checks these properties on every cycle:
- the selects are mutually exclusive and consistent with accept, and standby never appears together with accept;
- a strobe clears the outputs, and the outputs hold steady between decisions;
- an ID mismatch or an A22 = 0 cycle never yields flash-select one cycle after the strobe.

Other behaviour is shown only by the bench scenarios, each computed from its own model of the address layout:
- the exact bit placement of the ID field;
- the range limits at their boundary offsets;
- acceptance of matching IDs across different strap values, including the boot strap;
- clearing by reset in the middle of a run.

// File: rtl/baid_pkg.sv
package baid_pkg;
  localparam int ADDR_W  = 24;
  localparam int ID_W    = 4;
  localparam int TGT_BIT = 22;
  localparam int OFF_TOP = 18;

  // Address position of strap bit i: bit 3 sits at A23, bits 2..0 at A21..A19
  function automatic int id_pos(input int i);
    return (i == ID_W - 1) ? 23 : 19 + i;
  endfunction

  typedef struct packed {
    logic accept;
    logic flash;
    logic regs;
    logic standby;
  } baid_res_t;
endpackage

// File: rtl/baid_capture.sv
module baid_capture #(
  parameter int AW  = 24,
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  addr_in,
  input  logic [IDW-1:0] strap_in,
  output logic [AW-1:0]  addr_q,
  output logic [IDW-1:0] strap_q,
  output logic           pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      strap_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= start;
      if (start) begin
        addr_q  <= addr_in;
        strap_q <= strap_in;
      end
    end
  end
endmodule

// File: rtl/baid_id_cmp.sv
module baid_id_cmp
  import baid_pkg::*;
#(
  parameter int AW  = 24,
  parameter int IDW = 4
) (
  input  logic [AW-1:0]  addr,
  input  logic [IDW-1:0] strap,
  output logic           match
);
  logic [IDW-1:0] bit_ok;

  // Field is stored inverted, so a differing bit pair means the bit agrees
  for (genvar i = 0; i < IDW; i++) begin : g_bit
    assign bit_ok[i] = addr[id_pos(i)] ^ strap[i];
  end

  assign match = &bit_ok;
endmodule

// File: rtl/baid_range_chk.sv
module baid_range_chk
  import baid_pkg::*;
#(
  parameter int AW       = 24,
  parameter int ARRAY_AW = 19,
  parameter int REG_AW   = 16
) (
  input  logic [AW-1:0] addr,
  output logic          in_range
);
  localparam int OFF_W = OFF_TOP + 1;
  localparam logic [OFF_W:0]   FL_LIM  = (OFF_W+1)'(1) << ARRAY_AW;
  localparam logic [OFF_W:0]   RG_LIM  = (OFF_W+1)'(1) << REG_AW;
  localparam logic [OFF_W-1:0] FL_MASK = ~(FL_LIM[OFF_W-1:0] - OFF_W'(1));
  localparam logic [OFF_W-1:0] RG_MASK = ~(RG_LIM[OFF_W-1:0] - OFF_W'(1));

  logic [OFF_W-1:0] off;
  logic             fl_ok;
  logic             rg_ok;

  assign off = addr[OFF_TOP:0];

  if (ARRAY_AW >= OFF_W) begin : g_fl_full
    assign fl_ok = 1'b1;
  end else begin : g_fl_part
    assign fl_ok = ~|(off & FL_MASK);
  end

  if (REG_AW >= OFF_W) begin : g_rg_full
    assign rg_ok = 1'b1;
  end else begin : g_rg_part
    assign rg_ok = ~|(off & RG_MASK);
  end

  assign in_range = addr[TGT_BIT] ? fl_ok : rg_ok;
endmodule

// File: rtl/bus_addr_id_decode.sv
module bus_addr_id_decode
  import baid_pkg::*;
#(
  parameter int ARRAY_AW = 19,
  parameter int REG_AW   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [ID_W-1:0]   id_strap,
  output logic              accept_o,
  output logic              flash_sel_o,
  output logic              reg_sel_o,
  output logic              standby_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   strap_q;
  logic              pend_q;
  logic              id_match;
  logic              in_range;
  baid_res_t         nxt;
  baid_res_t         res_q;

  baid_capture #(.AW(ADDR_W), .IDW(ID_W)) u_cap (
    .clk(clk), .rst(rst), .start(cyc_start),
    .addr_in(cyc_addr), .strap_in(id_strap),
    .addr_q(addr_q), .strap_q(strap_q), .pend_q(pend_q)
  );

  baid_id_cmp #(.AW(ADDR_W), .IDW(ID_W)) u_id (
    .addr(addr_q), .strap(strap_q), .match(id_match)
  );

  baid_range_chk #(.AW(ADDR_W), .ARRAY_AW(ARRAY_AW), .REG_AW(REG_AW)) u_rng (
    .addr(addr_q), .in_range(in_range)
  );

  always_comb begin
    nxt.accept  = id_match & in_range;
    nxt.flash   = nxt.accept & addr_q[TGT_BIT];
    nxt.regs    = nxt.accept & ~addr_q[TGT_BIT];
    nxt.standby = ~nxt.accept;
  end

  always_ff @(posedge clk) begin
    if (rst || cyc_start) begin
      res_q <= '0;
    end else if (pend_q) begin
      res_q <= nxt;
    end
  end

  assign accept_o    = res_q.accept;
  assign flash_sel_o = res_q.flash;
  assign reg_sel_o   = res_q.regs;
  assign standby_o   = res_q.standby;
endmodule

// File: rtl/baid_chk.sv
module baid_chk (
  input logic        clk,
  input logic        rst,
  input logic        cyc_start,
  input logic [23:0] cyc_addr,
  input logic [3:0]  id_strap,
  input logic        accept_o,
  input logic        flash_sel_o,
  input logic        reg_sel_o,
  input logic        standby_o,
  input logic        pend_q
);
  // R1
  rst_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> !accept_o && !flash_sel_o && !reg_sel_o && !standby_o);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !accept_o && !flash_sel_o && !reg_sel_o && !standby_o);

  // R4
  mismatch_standby_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && ((id_strap ^ {cyc_addr[23], cyc_addr[21:19]}) != 4'hF))
      ##1 !cyc_start |=> standby_o && !accept_o);

  // R5
  reg_target_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !cyc_addr[22]) ##1 !cyc_start |=> !flash_sel_o);

  // R5
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flash_sel_o, reg_sel_o}) && (accept_o == (flash_sel_o || reg_sel_o)));

  // R4
  standby_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(standby_o && accept_o));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start && !pend_q) |=>
      $stable({accept_o, flash_sel_o, reg_sel_o, standby_o}));
endmodule

bind bus_addr_id_decode baid_chk u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
  .id_strap(id_strap), .accept_o(accept_o), .flash_sel_o(flash_sel_o),
  .reg_sel_o(reg_sel_o), .standby_o(standby_o), .pend_q(pend_q)
);

// File: tb/bus_addr_id_decode_bench.sv
module bus_addr_id_decode_bench;
  localparam int AAW = 18;
  localparam int RAW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_start = 1'b0;
  logic [23:0] cyc_addr = '0;
  logic [3:0]  id_strap = '0;
  logic        accept_o, flash_sel_o, reg_sel_o, standby_o;

  int errors = 0;
  int checks = 0;

  typedef struct packed {
    logic a;
    logic f;
    logic r;
    logic s;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  bus_addr_id_decode #(.ARRAY_AW(AAW), .REG_AW(RAW)) u_bus_addr_id_decode (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
    .id_strap(id_strap), .accept_o(accept_o), .flash_sel_o(flash_sel_o),
    .reg_sel_o(reg_sel_o), .standby_o(standby_o)
  );

  function automatic logic [23:0] mk(input logic [3:0] id, input logic tgt,
                                     input logic [18:0] off);
    return {~id[3], tgt, ~id[2:0], off};
  endfunction

  function automatic exp_t model(input logic [23:0] a, input logic [3:0] st);
    exp_t e;
    logic idok, rok;
    idok = (~{a[23], a[21], a[20], a[19]}) == st;
    rok  = a[22] ? ((a[18:0] >> AAW) == 0) : ((a[18:0] >> RAW) == 0);
    e.a = idok && rok;
    e.f = e.a && a[22];
    e.r = e.a && !a[22];
    e.s = !e.a;
    return e;
  endfunction

  task automatic cmp(input string req, input exp_t exp);
    exp_t got;
    got = {accept_o, flash_sel_o, reg_sel_o, standby_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got acc/fl/rg/sb=%b expected %b", req, got, exp);
    end
  endtask

  task automatic issue(input string req, input logic [23:0] a,
                       input logic [3:0] st);
    @(negedge clk);
    cyc_addr  = a;
    id_strap  = st;
    cyc_start = 1'b1;
    sb_q.push_back(model(a, st));
    @(negedge clk);
    cmp("R2 clear on strobe", 4'b0000);
    cyc_start = 1'b0;
    cyc_addr  = ~a;
    repeat (3) @(negedge clk);
    if (req.len() == 0) $display("unnamed item");
  endtask

  // Monitor: pops expected decisions and compares, then checks hold (R8)
  initial begin
    forever begin
      @(posedge clk);
      if (cyc_start) begin
        @(posedge clk);
        @(negedge clk);
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          cmp("R3/R4/R5/R6/R7 decision", e);
          @(negedge clk);
          cmp("R8 hold", e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset", 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 idle after reset", 4'b0000);

    // R9 boot strap, R5 flash and register targets
    issue("R9", mk(4'h0, 1'b1, 19'h00000), 4'h0);
    issue("R5", mk(4'h0, 1'b0, 19'h00010), 4'h0);
    issue("R9", 24'hB80000, 4'h0);
    // R3 match with a nonzero strap, R4 one-bit mismatches
    issue("R3", mk(4'h3, 1'b1, 19'h01234), 4'h3);
    issue("R4", mk(4'h2, 1'b1, 19'h01234), 4'h3);
    issue("R4", mk(4'hB, 1'b0, 19'h00000), 4'h3);
    issue("R3", mk(4'hA, 1'b0, 19'h00FFF), 4'hA);
    // R6 flash range boundary
    issue("R6", mk(4'h5, 1'b1, 19'h40000), 4'h5);
    issue("R6", mk(4'h5, 1'b1, 19'h3FFFF), 4'h5);
    // R7 register range boundary
    issue("R7", mk(4'hF, 1'b0, 19'h10000), 4'hF);
    issue("R7", mk(4'hF, 1'b0, 19'h0FFFF), 4'hF);
    issue("R5", mk(4'hF, 1'b1, 19'h00001), 4'hF);

    // R1 reset in the middle of a run clears an accepted decision
    issue("R1", mk(4'h1, 1'b1, 19'h0), 4'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    cmp("R1 mid-run reset", 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 after reset release", 4'b0000);

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule